// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers one non-maskable interrupt input and a parameterized set of maskable request lines, such as external interrupt pins and on-chip peripheral requests. Each maskable source carries a 4-bit priority level that is written through a simple configuration port. In every idle cycle the block picks the strongest eligible request and presents it to the processor. A maskable source is eligible only when its level is strictly above the 4-bit mask level that the processor supplies from its status register. The non-maskable input sits at a fixed level 16 above every programmable level and is always eligible.

The presented interrupt is a valid/ready style transfer. `int_valid` is the valid signal and `int_ack` is the ready signal. While `int_valid` is high, the vector and the new mask value stay frozen, whatever happens on the request lines, the mask input or the configuration port. The processor has no way to stall the block other than by not acknowledging. A transfer completes on a cycle in which both `int_valid` and `int_ack` are high. `int_valid` then falls on the next edge, and a fresh arbitration may raise it again one edge later. The block does not queue anything. Maskable requests are level-sensitive and have to be cleared at their origin. The non-maskable input is edge-captured into a pending flag, and acknowledging that interrupt clears the flag.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `int_valid` is low and every source's priority level is 0.
- R2: A cycle with `cfg_we` high stores `cfg_level` as the level of source `cfg_sel`. A `cfg_sel` value of NUM_SRC or more changes no level.
- R3: A maskable request is presented only when its level is strictly greater than `cpu_mask`. A level equal to the mask is not presented.
- R4: A source whose level is 0 is never presented, whatever the mask value.
- R5: When several eligible maskable requests are pending, the one with the highest level is presented.
- R6: Among eligible requests of equal level, the lowest-numbered source is presented.
- R7: A rising edge on `nmi_in` is captured and presented regardless of `cpu_mask`, including mask 15. At arbitration it wins over any maskable request.
- R8: A presented non-maskable interrupt carries vector VEC_NMI (default 11) and new mask 4'hF.
- R9: A presented maskable source i carries vector VEC_BASE + i (default 64 + i) and, as its new mask, its own level.
- R10: While `int_valid` is high and `int_ack` is low, `int_valid`, `int_vector` and `int_new_mask` hold their values. A cycle with both high drops `int_valid` on the next edge. The earliest new presentation comes one edge later.
- R11: The pending non-maskable flag is cleared only by acknowledging it. Holding `nmi_in` high does not present it again. Only a new rising edge does.
- R12: `int_ack` while `int_valid` is low has no effect, including on a pending non-maskable interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_in | input | 1 | Non-maskable interrupt, rising-edge sensitive |
| irq_req | input | NUM_SRC | Level-sensitive maskable requests, bit i is source i |
| cfg_we | input | 1 | Priority level write enable |
| cfg_sel | input | SEL_W | Source index for the write |
| cfg_level | input | 4 | Level to store |
| cpu_mask | input | 4 | Current processor mask level |
| int_valid | output | 1 | Interrupt presented (valid) |
| int_ack | input | 1 | Processor accepts the presented interrupt (ready) |
| int_vector | output | VEC_W | Vector number of the presented interrupt |
| int_new_mask | output | 4 | Mask value for the processor to load |

## Verification
Most wrong internal states in this block become visible at the ports within two edges. A corrupted stored level shows up at the next arbitration, either as the wrong winner or as a new-mask value that does not match the programmed level. A stuck or lost pending flag for the non-maskable input shows up in one of two ways. It can give a repeated presentation after acknowledge while `nmi_in` stays high. It can also give a missing presentation two edges after a rising edge. A holding register that moves before acknowledge shows up in the very next sample as a changed vector, even though the requests feeding the arbiter have changed in the meantime.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int LVL_W = 4;
  typedef logic [LVL_W-1:0] lvl_t;
  // mask written back when the non-maskable interrupt is taken
  localparam lvl_t NMI_NEW_MASK = 4'hF;
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int SEL_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [SEL_W-1:0]        cfg_sel,
  input  lvl_t                    cfg_level,
  output lvl_t [NUM_SRC-1:0]      levels
);
  // one level register per source; an out-of-range index matches no slot
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        levels[g] <= '0;
      else if (cfg_we && cfg_sel == SEL_W'(g))
        levels[g] <= cfg_level;
    end
  end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_SRC-1:0]  req,
  input  lvl_t [NUM_SRC-1:0]  levels,
  input  lvl_t                mask,
  output logic                found,
  output logic [IDX_W-1:0]    win_idx,
  output lvl_t                win_lvl
);
  logic [NUM_SRC-1:0] eligible;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
    assign eligible[g] = req[g] && (levels[g] > mask);
  end

  // ascending scan with strict compare keeps the lowest index on ties
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (eligible[i] && (!found || levels[i] > win_lvl)) begin
        found   = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = levels[i];
      end
    end
  end
endmodule

// File: rtl/irq_nmi_capture.sv
module irq_nmi_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic clr,
  output logic pending
);
  logic nmi_d;
  logic edge_seen;

  assign edge_seen = nmi_in && !nmi_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_d   <= 1'b0;
      pending <= 1'b0;
    end else begin
      nmi_d   <= nmi_in;
      // a fresh edge wins over a same-cycle clear
      pending <= (pending && !clr) || edge_seen;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int             NUM_SRC  = 8,
  parameter int             SEL_W    = $clog2(NUM_SRC) + 1,
  parameter int             VEC_W    = 8,
  parameter logic [VEC_W-1:0] VEC_NMI  = 8'd11,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'd64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nmi_in,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [3:0]         cfg_level,
  input  logic [3:0]         cpu_mask,
  output logic               int_valid,
  input  logic               int_ack,
  output logic [VEC_W-1:0]   int_vector,
  output logic [3:0]         int_new_mask
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  lvl_t [NUM_SRC-1:0] levels;
  logic               win_found;
  logic [IDX_W-1:0]   win_idx;
  lvl_t               win_lvl;
  logic               nmi_pending;
  logic               nmi_taken_q;
  logic               nmi_clr;

  irq_prio_regs #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_level(cfg_level), .levels(levels)
  );

  irq_prio_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) arb_i (
    .req(irq_req), .levels(levels), .mask(cpu_mask),
    .found(win_found), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  assign nmi_clr = int_valid && int_ack && nmi_taken_q;

  irq_nmi_capture nmi_i (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .clr(nmi_clr),
    .pending(nmi_pending)
  );

  // presentation register: loads only when idle, frees only on acknowledge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_valid    <= 1'b0;
      int_vector   <= '0;
      int_new_mask <= '0;
      nmi_taken_q  <= 1'b0;
    end else if (int_valid) begin
      if (int_ack) int_valid <= 1'b0;
    end else if (nmi_pending) begin
      int_valid    <= 1'b1;
      int_vector   <= VEC_NMI;
      int_new_mask <= NMI_NEW_MASK;
      nmi_taken_q  <= 1'b1;
    end else if (win_found) begin
      int_valid    <= 1'b1;
      int_vector   <= VEC_BASE + VEC_W'(win_idx);
      int_new_mask <= win_lvl;
      nmi_taken_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int               VEC_W   = 8,
  parameter logic [VEC_W-1:0] VEC_NMI = 8'd11
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       cpu_mask,
  input logic             int_valid,
  input logic             int_ack,
  input logic [VEC_W-1:0] int_vector,
  input logic [3:0]       int_new_mask
);
  // R10: payload frozen until acknowledge
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (int_valid && !int_ack) |=> (int_valid && $stable(int_vector) && $stable(int_new_mask)));

  // R10: acknowledge frees the presentation on the next edge
  a_r10_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (int_valid && int_ack) |=> !int_valid);

  // R8: non-maskable vector always carries mask 15
  a_r8_nmi_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (int_valid && int_vector == VEC_NMI) |-> int_new_mask == 4'hF);

  // R3: a newly presented maskable level lies above the mask it was judged against
  a_r3_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(int_valid) && int_vector != VEC_NMI) |-> int_new_mask > $past(cpu_mask));

  // R4: level 0 never reaches the processor
  a_r4_no_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (int_valid && int_vector != VEC_NMI) |-> int_new_mask != 4'h0);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.VEC_W(VEC_W), .VEC_NMI(VEC_NMI)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_mask(cpu_mask), .int_valid(int_valid),
  .int_ack(int_ack), .int_vector(int_vector), .int_new_mask(int_new_mask)
);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
  localparam int N     = 8;
  localparam int SEL_W = 4;
  localparam int VNMI  = 11;
  localparam int VBASE = 64;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         nmi_in;
  logic [N-1:0] irq_req;
  logic         cfg_we;
  logic [SEL_W-1:0] cfg_sel;
  logic [3:0]   cfg_level;
  logic [3:0]   cpu_mask;
  logic         int_valid;
  logic         int_ack;
  logic [7:0]   int_vector;
  logic [3:0]   int_new_mask;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .irq_req(irq_req),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_level(cfg_level),
    .cpu_mask(cpu_mask), .int_valid(int_valid), .int_ack(int_ack),
    .int_vector(int_vector), .int_new_mask(int_new_mask)
  );

  // one edge, then sample mid-cycle
  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_idle(input string req);
    chk(int_valid == 1'b0, req, int_valid, 0);
  endtask

  task automatic expect_int(input string req, input int vec, input int msk);
    chk(int_valid == 1'b1, req, int_valid, 1);
    chk(int_vector == vec[7:0], req, int_vector, vec);
    chk(int_new_mask == msk[3:0], req, int_new_mask, msk);
  endtask

  task automatic set_level(input int src, input int lvl);
    cfg_we = 1'b1; cfg_sel = SEL_W'(src); cfg_level = lvl[3:0];
    cyc();
    cfg_we = 1'b0;
  endtask

  // acknowledge with the given requests left standing; valid drops next edge
  task automatic ack_with(input logic [N-1:0] remaining, input string req);
    int_ack = 1'b1; irq_req = remaining;
    cyc();
    int_ack = 1'b0;
    expect_idle(req);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; nmi_in = 0; irq_req = '0; cfg_we = 0; cfg_sel = '0;
    cfg_level = '0; cpu_mask = '0; int_ack = 0;
    cyc(3);
    expect_idle("R1");
    rst_n = 1'b1;
    irq_req = '1;
    cyc(3);
    expect_idle("R1 R4 levels zero after reset");
    cpu_mask = 4'd15;
    cyc();
    irq_req = '0; cpu_mask = 4'd0;
    cyc();
  endtask

  task automatic t_basic;
    set_level(3, 5);
    cpu_mask = 4'd4; irq_req = 8'b0000_1000;
    cyc();
    expect_int("R2 R9", VBASE + 3, 5);
    ack_with('0, "R10 drop");
    cyc();
    expect_idle("R10 no request");
  endtask

  task automatic t_strict;
    cpu_mask = 4'd5; irq_req = 8'b0000_1000;
    cyc(2);
    expect_idle("R3 equal level");
    cpu_mask = 4'd4;
    cyc();
    expect_int("R3 above", VBASE + 3, 5);
    ack_with('0, "R10");
    set_level(0, 0);
    cpu_mask = 4'd0; irq_req = 8'b0000_0001;
    cyc(2);
    expect_idle("R4 level 0 mask 0");
    irq_req = '0;
  endtask

  task automatic t_out_of_range;
    set_level(0, 2);
    set_level(8, 15);
    cpu_mask = 4'd2; irq_req = 8'b0000_0001;
    cyc(2);
    expect_idle("R2 out-of-range write ignored");
    cpu_mask = 4'd1;
    cyc();
    expect_int("R2 src0 kept level", VBASE + 0, 2);
    ack_with('0, "R10");
  endtask

  task automatic t_priority;
    set_level(1, 3); set_level(6, 9);
    cpu_mask = 4'd0; irq_req = 8'b0100_1010;
    cyc();
    expect_int("R5 highest", VBASE + 6, 9);
    ack_with(8'b0000_1010, "R10 drop");
    cyc();
    expect_int("R5 R10 re-arbitrate", VBASE + 3, 5);
    ack_with('0, "R10");
  endtask

  task automatic t_tie_hold;
    set_level(2, 7); set_level(5, 7);
    irq_req = 8'b0010_0100;
    cyc();
    expect_int("R6 tie lowest", VBASE + 2, 7);
    irq_req = 8'b0100_0000; cpu_mask = 4'd8;
    set_level(2, 1);
    cyc(2);
    expect_int("R10 hold", VBASE + 2, 7);
    cpu_mask = 4'd0;
    ack_with(8'b0100_0000, "R10");
    cyc();
    expect_int("R10 next", VBASE + 6, 9);
  endtask

  task automatic t_nmi;
    // src6 currently presented; raise the non-maskable input meanwhile
    nmi_in = 1'b1;
    cyc();
    expect_int("R10 hold over nmi", VBASE + 6, 9);
    ack_with(8'b0100_0000, "R10");
    cyc();
    expect_int("R7 R8 nmi wins", VNMI, 15);
    ack_with('0, "R10");
    cpu_mask = 4'd15;
    cyc(3);
    expect_idle("R11 held level no repeat");
    nmi_in = 1'b0;
    cyc();
    nmi_in = 1'b1; int_ack = 1'b1;
    cyc();
    int_ack = 1'b0;
    cyc();
    expect_int("R7 R12 mask 15, idle ack ignored", VNMI, 15);
    cyc(2);
    expect_int("R10 nmi held", VNMI, 15);
    ack_with('0, "R11");
    cyc(2);
    expect_idle("R11 cleared");
    nmi_in = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_strict();
    t_out_of_range();
    t_priority();
    t_tie_hold();
    t_nmi();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule